// File: doc/BRIEF.md
# I2C Target Serial Front End

This block is the bus side of a small byte-addressed serial memory that answers as an I2C target. The system clock samples SCL and SDA through synchronizers. The block finds start, repeated start and stop conditions and checks the control byte against a fixed device code and three strap inputs. It acknowledges received bytes and shifts bytes in and out, most significant bit first. The memory core sits behind a plain byte interface. Toward the core the block sends a word address load, write data strobes, read data requests and a commit pulse. From the core it takes the read data and a busy flag.

While the core reports busy, the block refuses every acknowledge, the control byte included. A controller can therefore poll for the end of an internal write by sending write-direction control bytes until one is acknowledged. The SDA output is modelled as an open-drain drive-low enable. It changes only a programmable number of clock cycles after a synchronized SCL falling edge.

Top module: `i2c_tgt`

## Requirements
- R1: A falling SDA while SCL is high begins a new transfer, and a rising SDA while SCL is high ends it. This holds even in the middle of a byte. SDA changes while SCL is low are only data bits.
- R2: The first byte after a start is the control byte. Bits 7..4 must equal 1010, otherwise the block never drives SDA until the next start.
- R3: Control bits 3, 2 and 1 must equal cs_strap[2], cs_strap[1] and cs_strap[0]. On a mismatch the block stays silent.
- R4: Control bit 0 selects the direction: 1 is a read from the current core address, 0 is a write.
- R5: An acknowledge holds sda_drive_low high for the whole high period of the ninth SCL pulse of the byte.
- R6: While core_busy is high, no byte receives an acknowledge. This covers control bytes of either direction.
- R7: In a write, the byte after the control byte appears on word_addr with a one-cycle addr_load pulse. Each later byte appears on wr_data with a one-cycle wr_valid pulse.
- R8: A repeated start after the word address ends the write without a commit. A following read control byte then returns data from that address.
- R9: When the controller answers a transmitted byte with NACK, the block releases SDA and transmits nothing more.
- R10: Bytes are shifted most significant bit first. sda_drive_low changes only HOLD_CYC cycles after a synchronized SCL fall, never while SCL is high.
- R11: A stop that ends a write with at least one data byte gives exactly one commit pulse. Any other stop gives none.
- R12: One rd_req pulse is issued per transmitted byte: after the read control byte is acknowledged, and after each controller ACK. rd_data must be valid the cycle after rd_req.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| cs_strap | input | 3 | Chip-select strap levels |
| sda_drive_low | output | 1 | Open-drain enable: 1 pulls SDA low |
| core_busy | input | 1 | Core internal write in progress |
| rd_data | input | 8 | Byte returned by the core after rd_req |
| word_addr | output | 8 | Received word address |
| addr_load | output | 1 | Pulse: word_addr is valid |
| wr_data | output | 8 | Received write data byte |
| wr_valid | output | 1 | Pulse: wr_data is valid |
| rd_req | output | 1 | Pulse: core must supply the next read byte |
| commit | output | 1 | Pulse: stop ended a write with data |

## Verification
A level change on SCL or SDA reaches the engine three cycles later: two synchronizer flops plus the edge register. The acknowledge or data drive then follows HOLD_CYC cycles after that. The address and data strobes appear one cycle after the synchronized falling edge that opens the acknowledge slot. The bench moves SDA only a quarter bit period (8 cycles) after each SCL edge and samples the bus in the middle of the high phase, so every result has settled before it is read. Commit and strobe counters are read at least 16 cycles after the stop or byte that caused them.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

    localparam logic [3:0] DEV_CODE = 4'b1010;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CTRL,
        ST_ADDR,
        ST_WDATA,
        ST_READ
    } tgt_state_e;

    // synchronized bus view plus the events derived from it
    typedef struct packed {
        logic scl;
        logic sda;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } bus_ev_t;

    function automatic logic ctrl_match(input logic [7:0] ctrl, input logic [2:0] cs);
        return (ctrl[7:4] == DEV_CODE) && (ctrl[3:1] == cs);
    endfunction

endpackage

// File: rtl/i2c_tgt_sync.sv
module i2c_tgt_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic [STAGES-1:0] ff;
        always_ff @(posedge clk) begin
            if (rst) ff <= '1;
            else     ff <= {ff[STAGES-2:0], d[i]};
        end
        assign q[i] = ff[STAGES-1];
    end
endmodule

// File: rtl/i2c_tgt_cond.sv
module i2c_tgt_cond
    import i2c_tgt_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_s,
    input  logic    sda_s,
    output bus_ev_t ev
);
    logic scl_q, sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    always_comb begin
        ev.scl      = scl_s;
        ev.sda      = sda_s;
        ev.scl_rise = scl_s & ~scl_q;
        ev.scl_fall = ~scl_s & scl_q;
        ev.start    = scl_s & scl_q & sda_q & ~sda_s;
        ev.stop     = scl_s & scl_q & ~sda_q & sda_s;
    end
endmodule

// File: rtl/i2c_tgt_engine.sv
module i2c_tgt_engine
    import i2c_tgt_pkg::*;
#(
    parameter int HOLD_CYC = 3
) (
    input  logic       clk,
    input  logic       rst,
    input  bus_ev_t    ev,
    input  logic [2:0] cs_strap,
    input  logic       busy_i,
    input  logic [7:0] rdata_i,
    output logic       sda_oe,
    output logic [7:0] word_addr,
    output logic       addr_load,
    output logic [7:0] wdata,
    output logic       wdata_valid,
    output logic       rd_req,
    output logic       commit
);
    localparam int          HW        = $clog2(HOLD_CYC + 1);
    localparam logic [3:0]  ACK_SLOT  = 4'd8;
    localparam logic [HW-1:0] HOLD_INIT = HW'(HOLD_CYC);

    tgt_state_e    st;
    logic [3:0]    bitcnt;
    logic [7:0]    shreg;
    logic          ack_q, wdirty, load_q;
    logic [HW-1:0] hold_cnt;
    logic          want, rx_st, accept;

    always_comb begin
        rx_st  = (st == ST_CTRL) || (st == ST_ADDR) || (st == ST_WDATA);
        accept = !busy_i && ((st != ST_CTRL) || ctrl_match(shreg, cs_strap));
        want   = ack_q || ((st == ST_READ) && (bitcnt < ACK_SLOT) && !shreg[7]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st          <= ST_IDLE;
            bitcnt      <= '0;
            shreg       <= '0;
            ack_q       <= 1'b0;
            wdirty      <= 1'b0;
            load_q      <= 1'b0;
            hold_cnt    <= '0;
            sda_oe      <= 1'b0;
            word_addr   <= '0;
            wdata       <= '0;
            addr_load   <= 1'b0;
            wdata_valid <= 1'b0;
            rd_req      <= 1'b0;
            commit      <= 1'b0;
        end else begin
            addr_load   <= 1'b0;
            wdata_valid <= 1'b0;
            rd_req      <= 1'b0;
            commit      <= 1'b0;
            load_q      <= rd_req;
            if (load_q) shreg <= rdata_i;
            if (hold_cnt != '0) hold_cnt <= hold_cnt - HW'(1);
            if (hold_cnt == HW'(1)) sda_oe <= want;

            if (ev.start) begin
                st       <= ST_CTRL;
                bitcnt   <= '0;
                ack_q    <= 1'b0;
                wdirty   <= 1'b0;
                sda_oe   <= 1'b0;
                hold_cnt <= '0;
            end else if (ev.stop) begin
                st       <= ST_IDLE;
                commit   <= wdirty;
                wdirty   <= 1'b0;
                ack_q    <= 1'b0;
                sda_oe   <= 1'b0;
                hold_cnt <= '0;
            end else if (st != ST_IDLE) begin
                if (ev.scl_fall) begin
                    hold_cnt <= HOLD_INIT;
                    if (rx_st && bitcnt == ACK_SLOT) begin
                        if (accept) begin
                            ack_q <= 1'b1;
                            if (st == ST_ADDR) begin
                                word_addr <= shreg;
                                addr_load <= 1'b1;
                            end else if (st == ST_WDATA) begin
                                wdata       <= shreg;
                                wdata_valid <= 1'b1;
                                wdirty      <= 1'b1;
                            end
                        end else begin
                            st <= ST_IDLE;
                        end
                    end else begin
                        ack_q <= 1'b0;
                        if (st == ST_READ && bitcnt != '0 && bitcnt < ACK_SLOT)
                            shreg <= {shreg[6:0], 1'b0};
                    end
                end else if (ev.scl_rise) begin
                    if (bitcnt < ACK_SLOT) begin
                        bitcnt <= bitcnt + 4'd1;
                        if (rx_st) shreg <= {shreg[6:0], ev.sda};
                    end else begin
                        bitcnt <= '0;
                        case (st)
                            ST_CTRL: begin
                                if (shreg[0]) begin
                                    st     <= ST_READ;
                                    rd_req <= 1'b1;
                                end else begin
                                    st <= ST_ADDR;
                                end
                            end
                            ST_ADDR: st <= ST_WDATA;
                            ST_READ: begin
                                if (!ev.sda) rd_req <= 1'b1;
                                else         st     <= ST_IDLE;
                            end
                            default: ;
                        endcase
                    end
                end
            end
        end
    end

    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IDLE) |-> !sda_oe);

    p_ack_held_r5: assert property (@(posedge clk) disable iff (rst)
        (ack_q && ev.scl) |-> sda_oe);

    p_busy_no_ack_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(ack_q) |-> !$past(busy_i));

    p_single_strobe_r7: assert property (@(posedge clk) disable iff (rst)
        $onehot0({addr_load, wdata_valid, rd_req, commit}));

    p_hi_stable_r10: assert property (@(posedge clk) disable iff (rst)
        (ev.scl && $past(ev.scl)) |-> $stable(sda_oe));

    p_commit_on_stop_r11: assert property (@(posedge clk) disable iff (rst)
        commit |-> $past(ev.stop));
endmodule

// File: rtl/i2c_tgt.sv
module i2c_tgt
    import i2c_tgt_pkg::*;
#(
    parameter int HOLD_CYC    = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic [2:0] cs_strap,
    output logic       sda_drive_low,
    input  logic       core_busy,
    input  logic [7:0] rd_data,
    output logic [7:0] word_addr,
    output logic       addr_load,
    output logic [7:0] wr_data,
    output logic       wr_valid,
    output logic       rd_req,
    output logic       commit
);
    logic [1:0] raw_lines, sync_lines;
    bus_ev_t    ev;

    assign raw_lines = {scl_i, sda_i};

    i2c_tgt_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw_lines),
        .q   (sync_lines)
    );

    i2c_tgt_cond u_cond (
        .clk   (clk),
        .rst   (rst),
        .scl_s (sync_lines[1]),
        .sda_s (sync_lines[0]),
        .ev    (ev)
    );

    i2c_tgt_engine #(.HOLD_CYC(HOLD_CYC)) u_eng (
        .clk         (clk),
        .rst         (rst),
        .ev          (ev),
        .cs_strap    (cs_strap),
        .busy_i      (core_busy),
        .rdata_i     (rd_data),
        .sda_oe      (sda_drive_low),
        .word_addr   (word_addr),
        .addr_load   (addr_load),
        .wdata       (wr_data),
        .wdata_valid (wr_valid),
        .rd_req      (rd_req),
        .commit      (commit)
    );
endmodule

// File: tb/i2c_tgt_tb.sv
module i2c_tgt_tb;
    localparam int Q     = 8;
    localparam int BUSY  = 1500;
    localparam logic [2:0] CS = 3'b101;
    localparam logic [7:0] CTRL_W = {4'b1010, CS, 1'b0};
    localparam logic [7:0] CTRL_R = {4'b1010, CS, 1'b1};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl_m = 1'b1, sda_m = 1'b1;
    logic force_busy = 1'b0;
    logic sda_drive_low, addr_load, wr_valid, rd_req, commit, core_busy;
    logic [7:0] word_addr, wr_data, rd_data;
    wire  sda_bus = sda_m & ~sda_drive_low;

    always #2 clk = ~clk;

    i2c_tgt u_dut (
        .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_bus), .cs_strap(CS),
        .sda_drive_low(sda_drive_low), .core_busy(core_busy), .rd_data(rd_data),
        .word_addr(word_addr), .addr_load(addr_load), .wr_data(wr_data),
        .wr_valid(wr_valid), .rd_req(rd_req), .commit(commit)
    );

    // core model
    logic [7:0] mem [256];
    logic [7:0] ref_mem [256];
    logic [7:0] ptr;
    int busy_cnt = 0;
    int n_commit = 0, n_wr = 0, n_rdreq = 0, n_aload = 0;
    logic [7:0] last_addr = 8'h00, last_wdata = 8'h00;
    assign core_busy = force_busy || (busy_cnt != 0);

    always @(posedge clk) begin
        if (rst) begin
            ptr <= 8'h00; rd_data <= 8'h00; busy_cnt <= 0;
        end else begin
            if (addr_load) begin ptr <= word_addr; last_addr <= word_addr; n_aload <= n_aload + 1; end
            if (wr_valid) begin mem[ptr] <= wr_data; ptr <= ptr + 8'd1; last_wdata <= wr_data; n_wr <= n_wr + 1; end
            if (rd_req) begin rd_data <= mem[ptr]; ptr <= ptr + 8'd1; n_rdreq <= n_rdreq + 1; end
            if (commit) begin busy_cnt <= BUSY; n_commit <= n_commit + 1; end
            else if (busy_cnt > 0) busy_cnt <= busy_cnt - 1;
        end
    end

    // drive must never move while SCL is high (R10)
    int hold_viol = 0;
    logic scl_prev = 1'b1, dl_prev = 1'b0;
    always @(negedge clk) begin
        if (!rst && scl_m && scl_prev && (sda_drive_low != dl_prev)) hold_viol <= hold_viol + 1;
        scl_prev <= scl_m;
        dl_prev  <= sda_drive_low;
    end

    int n_chk = 0, n_bad = 0;
    bit finished = 1'b0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic qtr();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; qtr(); scl_m = 1'b1; qtr(); sda_m = 1'b0; qtr(); scl_m = 1'b0; qtr();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; qtr(); scl_m = 1'b1; qtr(); sda_m = 1'b1; qtr(); qtr();
    endtask

    task automatic clk_bit(input logic b, output logic s);
        sda_m = b; qtr(); scl_m = 1'b1; qtr(); s = sda_bus; qtr(); scl_m = 1'b0; qtr();
    endtask

    task automatic wr_byte(input logic [7:0] b, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
        clk_bit(1'b1, s);
        ack = !s;
    endtask

    task automatic rd_byte(input logic give_ack, output logic [7:0] b);
        logic s;
        for (int i = 7; i >= 0; i--) begin clk_bit(1'b1, s); b[i] = s; end
        clk_bit(!give_ack, s);
    endtask

    task automatic do_write(input logic [7:0] a, input int len, input logic [7:0] seed_byte);
        logic ack;
        logic [7:0] d;
        bus_start();
        wr_byte(CTRL_W, ack);  chk(ack, "R4 write ctrl ack", ack, 1);
        wr_byte(a, ack);       chk(ack, "R5 addr ack", ack, 1);
        for (int k = 0; k < len; k++) begin
            d = seed_byte ^ 8'(k * 37);
            wr_byte(d, ack);
            ref_mem[8'(a + 8'(k))] = d;
        end
        bus_stop();
    endtask

    task automatic poll(output int nacks);
        logic ack;
        nacks = 0; ack = 1'b0;
        while (!ack) begin
            bus_start();
            wr_byte(CTRL_W, ack);
            if (!ack) begin nacks++; bus_stop(); end
        end
    endtask

    // continues an open write transfer: address, repeated start, read len bytes
    task automatic read_back(input logic [7:0] a, input int len, input string req);
        logic ack;
        logic [7:0] b;
        wr_byte(a, ack);
        bus_start();
        wr_byte(CTRL_R, ack);
        chk(ack, "R4 read ctrl ack", ack, 1);
        for (int k = 0; k < len; k++) begin
            rd_byte(k != len - 1, b);
            chk(b == ref_mem[8'(a + 8'(k))], req, b, ref_mem[8'(a + 8'(k))]);
        end
        qtr();
        chk(!sda_drive_low, "R9 released after NACK", sda_drive_low, 0);
        bus_stop();
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic ack, s;
        logic [7:0] b;
        int nacks, c0, w0, r0;
        void'($urandom(32'd4242));
        for (int i = 0; i < 256; i++) begin mem[i] = 8'(i * 7 + 3); ref_mem[i] = 8'(i * 7 + 3); end
        repeat (5) @(negedge clk);
        chk(!sda_drive_low && !addr_load && !wr_valid && !rd_req && !commit,
            "R2 reset quiet", {sda_drive_low, addr_load, wr_valid, rd_req, commit}, 0);
        rst = 1'b0;
        repeat (5) @(negedge clk);

        // R1: SDA wiggles with SCL low in idle, then stop in mid control byte
        scl_m = 1'b0; qtr(); sda_m = 1'b0; qtr(); sda_m = 1'b1; qtr(); scl_m = 1'b1; qtr();
        bus_start();
        for (int i = 7; i >= 4; i--) clk_bit(CTRL_W[i], s);
        bus_stop();
        chk(!sda_drive_low, "R1 aborted byte silent", sda_drive_low, 0);

        // R7 R11: byte write of two bytes
        w0 = n_wr; c0 = n_commit;
        do_write(8'h10, 2, 8'h5C);
        chk(last_addr == 8'h10, "R7 word address", last_addr, 8'h10);
        chk(n_wr - w0 == 2, "R7 data strobes", n_wr - w0, 2);
        chk(last_wdata == (8'h5C ^ 8'd37), "R7 last data", last_wdata, 8'h5C ^ 8'd37);
        chk(n_commit - c0 == 1, "R11 commit on stop", n_commit - c0, 1);

        // R6: polling during busy; R8: random read with repeated start
        poll(nacks);
        chk(nacks > 0, "R6 busy refuses ctrl", nacks, 1);
        c0 = n_commit;
        read_back(8'h10, 2, "R8 R10 random read");
        chk(n_commit == c0, "R8 no commit on repeated start", n_commit - c0, 0);

        // R4 current address read continues at 0x12
        bus_start();
        wr_byte(CTRL_R, ack);
        chk(ack, "R4 current read ack", ack, 1);
        rd_byte(1'b0, b);
        chk(b == ref_mem[8'h12], "R4 current address data", b, ref_mem[8'h12]);
        bus_stop();

        // R2 wrong device code, R3 wrong chip select
        bus_start(); wr_byte({4'b1011, CS, 1'b0}, ack); bus_stop();
        chk(!ack, "R2 wrong code NACK", ack, 0);
        bus_start(); wr_byte({4'b1010, 3'b100, 1'b0}, ack); bus_stop();
        chk(!ack, "R3 wrong strap NACK", ack, 0);

        // R6 read direction refused while busy
        force_busy = 1'b1;
        bus_start(); wr_byte(CTRL_R, ack); bus_stop();
        chk(!ack, "R6 busy read NACK", ack, 0);
        force_busy = 1'b0;

        // R11 address only, then stop: no commit
        c0 = n_commit;
        bus_start(); wr_byte(CTRL_W, ack); wr_byte(8'h40, ack); bus_stop();
        chk(n_commit == c0, "R11 no commit without data", n_commit - c0, 0);

        // R12 four-byte sequential read
        r0 = n_rdreq;
        bus_start(); wr_byte(CTRL_W, ack);
        read_back(8'hFD, 4, "R12 sequential read");
        chk(n_rdreq - r0 == 4, "R12 one request per byte", n_rdreq - r0, 4);

        // random write / poll / read back
        for (int it = 0; it < 10; it++) begin
            logic [7:0] a, sd;
            int len;
            a = 8'($urandom_range(0, 255));
            sd = 8'($urandom_range(0, 255));
            len = $urandom_range(1, 4);
            do_write(a, len, sd);
            poll(nacks);
            read_back(a, len, "R10 random readback");
        end

        chk(hold_viol == 0, "R10 drive stable while SCL high", hold_viol, 0);
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule